// File: doc/BRIEF.md
# Twin butterfly multiply round-shift

This block computes both outputs of an integer DCT/FFT butterfly in one operation. Two signed operands `a` and `b` are combined into a sum and a difference. Each is multiplied by a shared signed coefficient `c`. Each exact product is then divided by a power of two, with rounding: half of the divisor is added and the result is shifted arithmetically by the shift amount `n`. The two XLEN-bit results are registered and appear together, one cycle after the operation is accepted. A typical fixed-point DCT stage uses `n = 14`. With `n = 0` the exact products are passed through, so that a later accumulate-then-shift step can finish the rounding.

The block also contains a combinational instruction-field extractor. It splits a 32-bit instruction word into the register indices and sub-fields that surrounding issue logic needs. These include the implicit second destination, which is one register above the first. Register-file access and sequencing are left to the surrounding pipeline.

Top module: `twin_bfly_rs`

## Requirements
- R1: When an operation is accepted, `sum_o` becomes the low XLEN bits of floor(((a+b)*c + h) / 2^n). Here a, b and c are two's-complement signed values, the product is exact, and h = 2^(n-1) for n > 0.
- R2: In the same operation, `dif_o` becomes the low XLEN bits of floor(((a-b)*c + h) / 2^n), using the same h and n.
- R3: The sum and the difference are formed at XLEN+1 bits and the product at full width. Extreme operands such as a = b = c = the largest positive value therefore give the mathematically exact product before truncation.
- R4: Rounding is round-half-up through a floor shift. For c = 1: with n = 1, a = 3 gives 2 and a = -3 gives -1. With n = 2, (a,b) = (5,2) gives a sum result of 2 and a difference result of 1.
- R5: When n = 0, no rounding increment is added, and each result equals the low XLEN bits of its exact product.
- R6: While `rst_ni` is low, `valid_o` is 0 and both result buses are 0. After reset, `valid_o` equals the value `valid_i` had at the previous rising clock edge, and the results of an operation appear in that same cycle.
- R7: While `valid_i` is low, changes on `a_i`, `b_i`, `c_i` and `shamt_i` leave `sum_o` and `dif_o` unchanged.
- R8: Instruction fields, counted with bit 31 as the most significant bit:
  - major opcode `insn_i[31:26]`
  - operand-a index `insn_i[25:21]`, which is also the sum destination
  - operand-b index `insn_i[20:16]`
  - coefficient index `insn_i[15:11]`
  - shift field `insn_i[10:6]`
  - minor opcode `insn_i[5:1]`
  - record bit `insn_i[0]`

  All of them are decoded combinationally.
- R9: The difference destination index is the operand-a index plus one, modulo 32, so index 31 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept an operation this cycle |
| a_i | input | XLEN | Signed operand a |
| b_i | input | XLEN | Signed operand b |
| c_i | input | XLEN | Signed coefficient |
| shamt_i | input | 5 | Right-shift amount n |
| insn_i | input | 32 | Instruction word to decode |
| valid_o | output | 1 | Results updated this cycle |
| sum_o | output | XLEN | Rounded, shifted (a+b)*c |
| dif_o | output | XLEN | Rounded, shifted (a-b)*c |
| major_o | output | 6 | Major opcode field |
| minor_o | output | 5 | Minor opcode field |
| rc_o | output | 1 | Record bit |
| src_a_idx_o | output | 5 | Operand-a register index |
| src_b_idx_o | output | 5 | Operand-b register index |
| coef_idx_o | output | 5 | Coefficient register index |
| sh_field_o | output | 5 | Shift field of the instruction |
| dst_sum_idx_o | output | 5 | Destination of the sum result |
| dst_dif_idx_o | output | 5 | Implicit destination of the difference result |

## Verification
The sum path and the difference path always update in the same cycle from the same operands, shift amount and rounding increment. The bench therefore compares both buses at the same sample point, each against its own model.

The stimulus is chosen so that the two paths must differ, or must coincide, in known ways:
- b = 0 makes the two results equal.
- a = b makes the difference zero while the sum is not.
- Opposite-sign rounding cases exercise each path's floor direction.

Operations are streamed back to back, so a fresh pair is judged every cycle. The bench also checks that an idle cycle disturbs neither result.

// File: rtl/twin_bfly_pkg.sv
package twin_bfly_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int SHAMT_W   = 5;

  // Packed from MSB down: field order is fixed by the instruction encoding.
  typedef struct packed {
    logic [5:0]           major;
    logic [REG_IDX_W-1:0] tgt;
    logic [REG_IDX_W-1:0] opb;
    logic [REG_IDX_W-1:0] coef;
    logic [SHAMT_W-1:0]   sh;
    logic [4:0]           minor;
    logic                 rc;
  } bfly_insn_t;
endpackage

// File: rtl/bfly_insn_dec.sv
module bfly_insn_dec
  import twin_bfly_pkg::*;
(
  input  logic [INSN_W-1:0]    insn_i,
  output logic [5:0]           major_o,
  output logic [4:0]           minor_o,
  output logic                 rc_o,
  output logic [REG_IDX_W-1:0] src_a_idx_o,
  output logic [REG_IDX_W-1:0] src_b_idx_o,
  output logic [REG_IDX_W-1:0] coef_idx_o,
  output logic [SHAMT_W-1:0]   sh_o,
  output logic [REG_IDX_W-1:0] dst_sum_idx_o,
  output logic [REG_IDX_W-1:0] dst_dif_idx_o
);
  bfly_insn_t f;
  assign f = bfly_insn_t'(insn_i);

  assign major_o       = f.major;
  assign minor_o       = f.minor;
  assign rc_o          = f.rc;
  assign src_a_idx_o   = f.tgt;
  assign src_b_idx_o   = f.opb;
  assign coef_idx_o    = f.coef;
  assign sh_o          = f.sh;
  assign dst_sum_idx_o = f.tgt;
  // implicit pair register, wraps modulo register count
  assign dst_dif_idx_o = f.tgt + REG_IDX_W'(1);
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN:0]   sum_o,
  output logic [XLEN:0]   dif_o
);
  assign sum_o = {a_i[XLEN-1], a_i} + {b_i[XLEN-1], b_i};
  assign dif_o = {a_i[XLEN-1], a_i} - {b_i[XLEN-1], b_i};

  logic [XLEN+1:0] span;
  always_comb begin
    span = {sum_o[XLEN], sum_o} - {dif_o[XLEN], dif_o};
    // R3: widened sum/difference never wrap, so their gap is exactly 2b
    a_r3_no_overflow: assert (span == {b_i[XLEN-1], b_i, 1'b0});
  end
endmodule

// File: rtl/bfly_scale_round.sv
module bfly_scale_round #(
  parameter int XLEN = 64,
  parameter int SHW  = 5
) (
  input  logic [XLEN:0]   op_i,
  input  logic [XLEN-1:0] c_i,
  input  logic [SHW-1:0]  n_i,
  output logic [XLEN-1:0] res_o
);
  // exact product of (XLEN+1)-bit by XLEN-bit signed values
  localparam int PW = 2*XLEN + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] biased;

  assign prod = $signed(op_i) * $signed(c_i);

  always_comb begin
    rnd = '0;
    if (n_i != '0) rnd[n_i - SHW'(1)] = 1'b1;
  end

  assign biased = prod + rnd;
  // window [n +: XLEN] equals the low XLEN bits of biased >>> n
  assign res_o  = biased[n_i +: XLEN];

  always_comb begin
    if (n_i == '0) begin
      a_r5_no_round_at_zero: assert (res_o == prod[XLEN-1:0]);
    end
  end
endmodule

// File: rtl/twin_bfly_rs.sv
module twin_bfly_rs
  import twin_bfly_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [XLEN-1:0]      a_i,
  input  logic [XLEN-1:0]      b_i,
  input  logic [XLEN-1:0]      c_i,
  input  logic [SHAMT_W-1:0]   shamt_i,
  input  logic [INSN_W-1:0]    insn_i,
  output logic                 valid_o,
  output logic [XLEN-1:0]      sum_o,
  output logic [XLEN-1:0]      dif_o,
  output logic [5:0]           major_o,
  output logic [4:0]           minor_o,
  output logic                 rc_o,
  output logic [REG_IDX_W-1:0] src_a_idx_o,
  output logic [REG_IDX_W-1:0] src_b_idx_o,
  output logic [REG_IDX_W-1:0] coef_idx_o,
  output logic [SHAMT_W-1:0]   sh_field_o,
  output logic [REG_IDX_W-1:0] dst_sum_idx_o,
  output logic [REG_IDX_W-1:0] dst_dif_idx_o
);
  localparam int NPATH = 2;

  bfly_insn_dec u_dec (
    .insn_i       (insn_i),
    .major_o      (major_o),
    .minor_o      (minor_o),
    .rc_o         (rc_o),
    .src_a_idx_o  (src_a_idx_o),
    .src_b_idx_o  (src_b_idx_o),
    .coef_idx_o   (coef_idx_o),
    .sh_o         (sh_field_o),
    .dst_sum_idx_o(dst_sum_idx_o),
    .dst_dif_idx_o(dst_dif_idx_o)
  );

  logic [XLEN:0]   opnd [NPATH];
  logic [XLEN-1:0] res  [NPATH];

  bfly_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i  (a_i),
    .b_i  (b_i),
    .sum_o(opnd[0]),
    .dif_o(opnd[1])
  );

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    bfly_scale_round #(.XLEN(XLEN), .SHW(SHAMT_W)) u_sr (
      .op_i (opnd[g]),
      .c_i  (c_i),
      .n_i  (shamt_i),
      .res_o(res[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      dif_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o <= res[0];
        dif_o <= res[1];
      end
    end
  end

  a_r6_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (valid_o == $past(valid_i)));

  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(valid_i)) |-> ($stable(sum_o) && $stable(dif_o)));

  a_r1_zero_b_twins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(valid_i) && ($past(b_i) == '0)) |-> (sum_o == dif_o));

  a_r2_equal_ops_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(valid_i) && ($past(a_i) == $past(b_i))) |-> (dif_o == '0));
endmodule

// File: tb/tb_twin_bfly_rs.sv
module tb_twin_bfly_rs;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [XL-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic [4:0]    shamt_i = '0;
  logic [31:0]   insn_i = '0;
  logic          valid_o;
  logic [XL-1:0] sum_o, dif_o;
  logic [5:0]    major_o;
  logic [4:0]    minor_o;
  logic          rc_o;
  logic [4:0]    src_a_idx_o, src_b_idx_o, coef_idx_o, sh_field_o, dst_sum_idx_o, dst_dif_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  twin_bfly_rs #(.XLEN(XL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .shamt_i(shamt_i), .insn_i(insn_i),
    .valid_o(valid_o), .sum_o(sum_o), .dif_o(dif_o),
    .major_o(major_o), .minor_o(minor_o), .rc_o(rc_o),
    .src_a_idx_o(src_a_idx_o), .src_b_idx_o(src_b_idx_o), .coef_idx_o(coef_idx_o),
    .sh_field_o(sh_field_o), .dst_sum_idx_o(dst_sum_idx_o), .dst_dif_idx_o(dst_dif_idx_o)
  );

  function automatic logic [XL-1:0] ref_rs(input logic signed [XL:0] s,
                                           input logic signed [XL-1:0] c, input int n);
    logic signed [2*XL+3:0] p;
    logic signed [2*XL+3:0] h;
    p = s * c;
    h = '0;
    if (n > 0) h[n-1] = 1'b1;
    p = p + h;
    p = p >>> n;
    return p[XL-1:0];
  endfunction

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, judge at the next falling edge (one register stage)
  task automatic op(input logic [XL-1:0] a, input logic [XL-1:0] b,
                    input logic [XL-1:0] c, input int n, input string tag);
    logic signed [XL:0] s, d;
    s = $signed(a) + $signed(b);
    d = $signed(a) - $signed(b);
    valid_i = 1'b1; a_i = a; b_i = b; c_i = c; shamt_i = 5'(n);
    @(negedge clk);
    chk({tag, " R6 valid"}, XL'(valid_o), XL'(1));
    chk({tag, " R1 sum"}, sum_o, ref_rs(s, $signed(c), n));
    chk({tag, " R2 dif"}, dif_o, ref_rs(d, $signed(c), n));
  endtask

  task automatic op_exp(input logic [XL-1:0] a, input logic [XL-1:0] b, input int n,
                        input logic [XL-1:0] es, input logic [XL-1:0] ed, input string tag);
    valid_i = 1'b1; a_i = a; b_i = b; c_i = XL'(1); shamt_i = 5'(n);
    @(negedge clk);
    chk({tag, " R4 sum"}, sum_o, es);
    chk({tag, " R4 dif"}, dif_o, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nsel [4] = '{0, 1, 14, 31};
    logic [XL-1:0] hs, hd;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk("R6 reset valid", XL'(valid_o), '0);
    chk("R6 reset sum", sum_o, '0);
    chk("R6 reset dif", dif_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle valid", XL'(valid_o), '0);

    // R8 field extraction and R9 implicit destination
    insn_i = {6'h04, 5'd7, 5'd9, 5'd12, 5'd14, 5'd17, 1'b1};
    #1;
    chk("R8 major", XL'(major_o), XL'(4));
    chk("R8 src_a", XL'(src_a_idx_o), XL'(7));
    chk("R8 src_b", XL'(src_b_idx_o), XL'(9));
    chk("R8 coef", XL'(coef_idx_o), XL'(12));
    chk("R8 sh", XL'(sh_field_o), XL'(14));
    chk("R8 minor", XL'(minor_o), XL'(17));
    chk("R8 rc", XL'(rc_o), XL'(1));
    chk("R8 dst_sum", XL'(dst_sum_idx_o), XL'(7));
    chk("R9 dst_dif", XL'(dst_dif_idx_o), XL'(8));
    insn_i = {6'h3f, 5'd31, 5'd0, 5'd31, 5'd0, 5'd0, 1'b0};
    #1;
    chk("R9 wrap", XL'(dst_dif_idx_o), XL'(0));
    chk("R8 rc0", XL'(rc_o), XL'(0));
    for (int k = 0; k < 20; k++) begin
      logic [31:0] w;
      w = $urandom;
      insn_i = w;
      #1;
      chk("R8 rand src_b", XL'(src_b_idx_o), XL'(w[20:16]));
      chk("R9 rand dif", XL'(dst_dif_idx_o), XL'(5'(w[25:21] + 5'd1)));
    end
    @(negedge clk);

    // R4 directed rounding
    op_exp(XL'(3), XL'(0), 1, XL'(2), XL'(2), "pos half");
    op_exp(-XL'(3), XL'(0), 1, -XL'(1), -XL'(1), "neg half");
    op_exp(XL'(5), XL'(2), 2, XL'(2), XL'(1), "n2");
    op_exp(XL'(1), XL'(0), 1, XL'(1), XL'(1), "one");

    // R3 extremes, R5 n=0
    op({1'b0, {(XL-1){1'b1}}}, {1'b0, {(XL-1){1'b1}}}, {1'b0, {(XL-1){1'b1}}}, 0, "R3 maxpos n0");
    op({1'b1, {(XL-1){1'b0}}}, {1'b0, {(XL-1){1'b1}}}, {1'b1, {(XL-1){1'b0}}}, 31, "R3 minneg n31");
    op({1'b1, {(XL-1){1'b0}}}, {1'b1, {(XL-1){1'b0}}}, {1'b1, {(XL-1){1'b0}}}, 14, "R3 allmin n14");
    op(XL'(1000), XL'(-200), XL'(-11585), 0, "R5 n0");
    op(XL'(12345), XL'(12345), XL'(11585), 14, "R2 a==b");
    op(XL'(-777), XL'(0), XL'(9999), 14, "R1 b0");

    // random stream, back to back
    for (int i = 0; i < 400; i++) begin
      logic [XL-1:0] ra, rb, rc;
      int n;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      if (i % 3 == 0) begin
        ra = XL'($signed(ra[31:0]));
        rb = XL'($signed(rb[31:0]));
        rc = XL'($signed(rc[15:0]));
      end
      n = (i % 2 == 0) ? nsel[i % 4 / 2 * 2 + ($urandom % 2)] : int'($urandom % 32);
      op(ra, rb, rc, n, "rand");
    end

    // R7 idle cycles with moving inputs
    hs = sum_o;
    hd = dif_o;
    valid_i = 1'b0;
    a_i = XL'(99); b_i = XL'(-5); c_i = XL'(123); shamt_i = 5'd3;
    @(negedge clk);
    chk("R6 valid drop", XL'(valid_o), '0);
    a_i = '1; c_i = XL'(7); shamt_i = 5'd0;
    @(negedge clk);
    chk("R7 hold sum", sum_o, hs);
    chk("R7 hold dif", dif_o, hd);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule